// File: doc/BRIEF.md
# Double Fault Escalation Tracker

This block follows exception delivery inside a processor core. It decides what happens when a second exception is detected while an earlier one is still being delivered to its handler. Each raised vector is sorted into one of three classes: benign, contributory or page fault. The class of the exception in flight and the class of the newcomer are then looked up in an asymmetric pair table. The outcome is one of three actions: deliver the newcomer serially, replace both with a double fault on vector 8, or, if the double fault itself is interrupted, stop the core in shutdown.

The core pulses `exc_valid` with `exc_vector` whenever it detects an exception. It pulses `deliver_done` once the handler has been entered. One cycle after each accepted strobe, the tracker presents the vector to deliver on its delivery outputs. With that vector it gives the error-code flag, the error-code value for the double-fault case, and the fault/trap/abort kind. Working out the error codes of other exceptions and invoking the handler belong to neighbouring logic.

The controller has four states:
- `ST_IDLE`: nothing is being delivered.
- `ST_SERV`: an ordinary exception is being delivered.
- `ST_DF`: a double fault is being delivered.
- `ST_HALT`: shutdown.

Its transitions are:
- *accept*: IDLE to SERV on a strobe.
- *serial*: SERV to SERV on a strobe that does not escalate.
- *escalate*: SERV to DF on a strobe that completes an escalating pair.
- *collapse*: DF to HALT on any strobe.
- *retire*: SERV or DF back to IDLE on `deliver_done` with no strobe.
- *hold*: HALT stays in HALT until reset.

Top module: `df_escalation_tracker`

## Requirements
- R1: A strobe in IDLE produces, on the following cycle, a one-cycle `dlv_valid` pulse with `dlv_vector` equal to the raised vector.
- R2: Vectors 0, 9, 10, 11, 12 and 13 are contributory. Vector 14 is the page-fault class. Every other vector, including reserved vectors and vectors 32 to 255, is benign.
- R3: A contributory strobe while a contributory exception is being delivered produces a delivery of vector 8 instead.
- R4: A contributory or page-fault strobe while a page fault is being delivered produces a delivery of vector 8.
- R5: Every other in-flight/new pairing is delivered serially: the new vector is presented and becomes the one in flight.
- R6: `dlv_has_err` is 1 exactly for vectors 8, 10, 11, 12, 13 and 14. On a double-fault delivery, `dlv_err_code` is all zeros.
- R7: `dlv_kind` encodes 0 = fault, 1 = trap (vectors 3 and 4), 2 = abort (vector 8). All other vectors are faults.
- R8: `deliver_done` without a strobe returns the tracker to IDLE. A strobe in the same cycle as `deliver_done` takes priority and is treated as raised during delivery. `deliver_done` in IDLE has no effect.
- R9: A strobe while a double fault is being delivered raises `shutdown` on the next cycle with no delivery pulse. `shutdown` then stays at 1 and all strobes and `deliver_done` are ignored until reset.
- R10: After reset, `dlv_valid`, `dlv_vector`, `dlv_has_err`, `dlv_kind` and `shutdown` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception detected this cycle |
| exc_vector | input | VEC_W | Vector of the detected exception |
| deliver_done | input | 1 | Handler entry finished for the delivery in flight |
| dlv_valid | output | 1 | One-cycle pulse: a new delivery is presented |
| dlv_vector | output | VEC_W | Vector to deliver |
| dlv_has_err | output | 1 | An error code is pushed for this delivery |
| dlv_err_code | output | ERR_W | Error-code value for the double-fault case (zero) |
| dlv_kind | output | 2 | 0 fault, 1 trap, 2 abort |
| shutdown | output | 1 | Sticky shutdown indication |

## Verification
The bench uses the defaults: an 8-bit vector, a 32-bit error code and vector 8 for the double fault. An 8-bit vector lets the stimulus reach the external-interrupt range (for example vector 40) and reserved numbers, so the benign fallback is exercised as well as the named classes. The bench walks every escalating pair and several serial pairs. It also covers chains in which a serial delivery changes the class in flight, the strobe-with-completion collision, and shutdown followed by reset.

// File: rtl/df_pkg.sv
package df_pkg;

    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2
    } exc_cls_e;

    typedef enum logic [1:0] {
        KIND_FAULT = 2'd0,
        KIND_TRAP  = 2'd1,
        KIND_ABORT = 2'd2
    } exc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SERV = 2'd1,
        ST_DF   = 2'd2,
        ST_HALT = 2'd3
    } trk_state_e;

endpackage

// File: rtl/df_vec_classify.sv
module df_vec_classify
    import df_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int DF_VEC = 8
) (
    input  logic [VEC_W-1:0] vec,
    output exc_cls_e         cls,
    output logic             has_err,
    output exc_kind_e        kind
);

    always_comb begin
        // R2: class sort, everything unnamed falls back to benign
        if (vec == VEC_W'(14)) begin
            cls = CLS_PAGE;
        end else if (vec inside {VEC_W'(0), VEC_W'(9), VEC_W'(10),
                                 VEC_W'(11), VEC_W'(12), VEC_W'(13)}) begin
            cls = CLS_CONTRIB;
        end else begin
            cls = CLS_BENIGN;
        end
    end

    // R6: vectors that push an error code
    assign has_err = vec inside {VEC_W'(DF_VEC), VEC_W'(10), VEC_W'(11),
                                 VEC_W'(12), VEC_W'(13), VEC_W'(14)};

    always_comb begin
        // R7: kind encoding
        if (vec == VEC_W'(DF_VEC)) begin
            kind = KIND_ABORT;
        end else if (vec == VEC_W'(3) || vec == VEC_W'(4)) begin
            kind = KIND_TRAP;
        end else begin
            kind = KIND_FAULT;
        end
    end

endmodule

// File: rtl/df_pair_rule.sv
module df_pair_rule
    import df_pkg::*;
(
    input  exc_cls_e first_cls,
    input  exc_cls_e second_cls,
    output logic     escalate
);

    logic contrib_pair;
    logic page_pair;

    // R3: contributory on contributory
    assign contrib_pair = (first_cls == CLS_CONTRIB) && (second_cls == CLS_CONTRIB);
    // R4: page fault followed by contributory or page fault
    assign page_pair    = (first_cls == CLS_PAGE) &&
                          ((second_cls == CLS_CONTRIB) || (second_cls == CLS_PAGE));
    assign escalate     = contrib_pair || page_pair;

endmodule

// File: rtl/df_escalation_tracker.sv
module df_escalation_tracker
    import df_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int ERR_W     = 32,
    parameter int DF_VECTOR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_valid,
    input  logic [VEC_W-1:0] exc_vector,
    input  logic             deliver_done,
    output logic             dlv_valid,
    output logic [VEC_W-1:0] dlv_vector,
    output logic             dlv_has_err,
    output logic [ERR_W-1:0] dlv_err_code,
    output logic [1:0]       dlv_kind,
    output logic             shutdown
);

    localparam logic [VEC_W-1:0] DF_VEC_L = VEC_W'(DF_VECTOR);

    trk_state_e       state_q, state_d;
    exc_cls_e         cur_cls_q;
    exc_cls_e         new_cls;
    logic             new_err;
    exc_kind_e        new_kind;
    logic             esc;

    logic             load;
    logic             load_df;
    logic [VEC_W-1:0] sel_vec;
    logic             sel_err;
    exc_kind_e        sel_kind;

    df_vec_classify #(
        .VEC_W  (VEC_W),
        .DF_VEC (DF_VECTOR)
    ) u_cls (
        .vec     (exc_vector),
        .cls     (new_cls),
        .has_err (new_err),
        .kind    (new_kind)
    );

    df_pair_rule u_rule (
        .first_cls  (cur_cls_q),
        .second_cls (new_cls),
        .escalate   (esc)
    );

    // next-state and load decisions
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        load_df = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (exc_valid) begin            // accept
                    state_d = ST_SERV;
                    load    = 1'b1;
                end
            end
            ST_SERV: begin
                if (exc_valid) begin
                    load = 1'b1;
                    if (esc) begin              // escalate
                        state_d = ST_DF;
                        load_df = 1'b1;
                    end
                end else if (deliver_done) begin // retire
                    state_d = ST_IDLE;
                end
            end
            ST_DF: begin
                if (exc_valid) begin            // collapse
                    state_d = ST_HALT;
                end else if (deliver_done) begin // retire
                    state_d = ST_IDLE;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;              // hold
            end
        endcase
    end

    assign sel_vec  = load_df ? DF_VEC_L   : exc_vector;
    assign sel_err  = load_df ? 1'b1       : new_err;
    assign sel_kind = load_df ? KIND_ABORT : new_kind;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_cls_q <= CLS_BENIGN;
        end else begin
            state_q <= state_d;
            if (load && !load_df) begin
                cur_cls_q <= new_cls;
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_valid   <= 1'b0;
            dlv_vector  <= '0;
            dlv_has_err <= 1'b0;
            dlv_kind    <= KIND_FAULT;
            shutdown    <= 1'b0;
        end else begin
            dlv_valid <= load;
            shutdown  <= (state_d == ST_HALT);
            if (load) begin
                dlv_vector  <= sel_vec;
                dlv_has_err <= sel_err;
                dlv_kind    <= sel_kind;
            end
        end
    end

    // R6: the double-fault error code is zero
    assign dlv_err_code = '0;

    p_df_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERV && exc_valid && cur_cls_q == CLS_CONTRIB && new_cls == CLS_CONTRIB)
        |=> (dlv_valid && dlv_vector == DF_VEC_L));

    p_page_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERV && exc_valid && cur_cls_q == CLS_PAGE && new_cls != CLS_BENIGN)
        |=> (dlv_valid && dlv_vector == DF_VEC_L && dlv_kind == KIND_ABORT));

    p_df_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && state_q == ST_DF) |-> (dlv_has_err && dlv_err_code == '0));

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && exc_valid) |=> (dlv_valid && dlv_vector == $past(exc_vector)));

    p_idle_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !exc_valid) |=> (!dlv_valid && state_q == ST_IDLE));

    p_shut_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (shutdown && !dlv_valid));

    p_collapse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DF && exc_valid) |=> (shutdown && !dlv_valid));

endmodule

// File: tb/df_escalation_tracker_tb_top.sv
`timescale 1ns/1ps
module df_escalation_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exc_valid = 1'b0;
    logic [7:0] exc_vector = '0;
    logic       deliver_done = 1'b0;
    logic       dlv_valid;
    logic [7:0] dlv_vector;
    logic       dlv_has_err;
    logic [31:0] dlv_err_code;
    logic [1:0] dlv_kind;
    logic       shutdown;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    df_escalation_tracker dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_valid    (exc_valid),
        .exc_vector   (exc_vector),
        .deliver_done (deliver_done),
        .dlv_valid    (dlv_valid),
        .dlv_vector   (dlv_vector),
        .dlv_has_err  (dlv_has_err),
        .dlv_err_code (dlv_err_code),
        .dlv_kind     (dlv_kind),
        .shutdown     (shutdown)
    );

    // ---------------- behavioural reference ----------------
    // mode: 0 idle, 1 ordinary delivery, 2 double fault, 3 halted
    int m_mode = 0;
    int m_cls  = 0;   // 0 benign, 1 contributory, 2 page
    int m_valid = 0, m_vec = 0, m_err = 0, m_kind = 0, m_shut = 0;

    function automatic int cls_of(input int v);
        if (v == 14) return 2;
        if (v == 0 || (v >= 9 && v <= 13)) return 1;
        return 0;
    endfunction

    function automatic int err_of(input int v);
        return (v == 8 || (v >= 10 && v <= 14)) ? 1 : 0;
    endfunction

    function automatic int kind_of(input int v);
        if (v == 8) return 2;
        if (v == 3 || v == 4) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cls = 0; m_valid = 0; m_vec = 0;
            m_err = 0; m_kind = 0; m_shut = 0;
        end else begin
            m_valid = 0;
            if (m_mode != 3) begin
                if (exc_valid) begin
                    int v;
                    int c;
                    v = int'(exc_vector);
                    c = cls_of(v);
                    if (m_mode == 2) begin
                        m_mode = 3; m_shut = 1;
                    end else if (m_mode == 1 &&
                                 ((m_cls == 1 && c == 1) || (m_cls == 2 && c != 0))) begin
                        m_mode = 2; m_valid = 1; m_vec = 8; m_err = 1; m_kind = 2;
                    end else begin
                        m_mode = 1; m_cls = c; m_valid = 1; m_vec = v;
                        m_err = err_of(v); m_kind = kind_of(v);
                    end
                end else if (deliver_done) begin
                    m_mode = 0;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 valid pulse", int'(dlv_valid), m_valid);
            chk("R5 vector", int'(dlv_vector), m_vec);
            chk("R6 err flag", int'(dlv_has_err), m_err);
            chk("R7 kind", int'(dlv_kind), m_kind);
            chk("R9 shutdown", int'(shutdown), m_shut);
            if (m_valid != 0 && m_vec == 8)
                chk("R6 df err code", int'(dlv_err_code), 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(input bit e, input int v, input bit d);
        exc_valid = e; exc_vector = 8'(v); deliver_done = d;
        @(negedge clk); #1;
        exc_valid = 1'b0; deliver_done = 1'b0;
    endtask

    task automatic raise(input int v);
        step(1'b1, v, 1'b0);
    endtask

    task automatic finish_dlv();
        step(1'b0, 0, 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R10 reset valid", int'(dlv_valid), 0);
        chk("R10 reset vector", int'(dlv_vector), 0);
        chk("R10 reset err", int'(dlv_has_err), 0);
        chk("R10 reset kind", int'(dlv_kind), 0);
        chk("R10 reset shutdown", int'(shutdown), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        @(negedge clk); #1;
        do_reset();

        // R1 simple page fault in idle
        raise(14);
        chk("R1 pf accepted", int'(dlv_valid), 1);
        chk("R1 pf vector", int'(dlv_vector), 14);
        finish_dlv();

        // R3 contributory on contributory
        raise(13);
        raise(11);
        chk("R3 df vector", int'(dlv_vector), 8);
        chk("R7 df abort", int'(dlv_kind), 2);
        finish_dlv();

        // R4 page fault then page fault
        raise(14);
        raise(14);
        chk("R4 pf pf df", int'(dlv_vector), 8);
        finish_dlv();

        // R4 page fault then divide error
        raise(14);
        raise(0);
        chk("R4 pf contrib df", int'(dlv_vector), 8);
        finish_dlv();

        // R5 contributory then page fault: serial, then page fault pair escalates
        raise(13);
        raise(14);
        chk("R5 contrib pf serial", int'(dlv_vector), 14);
        raise(14);
        chk("R4 chain df", int'(dlv_vector), 8);
        finish_dlv();

        // R2 benign chain including external and reserved vectors
        raise(40);
        raise(40);
        chk("R2 ext benign serial", int'(dlv_vector), 40);
        raise(4);
        chk("R7 trap kind", int'(dlv_kind), 1);
        raise(20);
        raise(12);
        chk("R2 reserved then contrib serial", int'(dlv_vector), 12);
        finish_dlv();

        // R8 strobe with done in same cycle counts as raised during delivery
        raise(10);
        step(1'b1, 13, 1'b1);
        chk("R8 collision escalates", int'(dlv_vector), 8);
        finish_dlv();
        // R8 done in idle ignored
        finish_dlv();
        chk("R8 idle done no pulse", int'(dlv_valid), 0);
        raise(13);
        chk("R8 fresh start after retire", int'(dlv_vector), 13);
        finish_dlv();

        // R9 shutdown path
        raise(3);
        raise(13);
        raise(12);
        chk("R9 df before collapse", int'(dlv_vector), 8);
        raise(6);
        chk("R9 shutdown raised", int'(shutdown), 1);
        chk("R9 no pulse on collapse", int'(dlv_valid), 0);
        raise(14);
        chk("R9 strobe ignored", int'(dlv_valid), 0);
        finish_dlv();
        raise(1);
        chk("R9 still halted", int'(shutdown), 1);
        chk("R9 vector held", int'(dlv_vector), 8);
        do_reset();

        raise(6);
        chk("R1 alive after reset", int'(dlv_vector), 6);
        finish_dlv();
        repeat (3) begin @(negedge clk); #1; end

        summary();
    end

endmodule